// File: doc/BRIEF.md
# Flash Privilege Watermark Checker

This block keeps one programmable length that divides a 256 KB flash space into two parts. Offsets below the watermark form the unprivileged area. Offsets at or above it are privileged. The length is counted in 2 KB pages from the bottom of the flash. Any value large enough to cover the whole space is clamped to exactly the whole space.

Software programs the length through a small register port. The port carries an address, read and write strobes, write data, and two attributes for each transaction: secure or non-secure, and privileged or unprivileged. Whether a write is accepted depends on those attributes, on a flash-secure option input, and on a configuration lock input that another block owns. A write that is not accepted is dropped and produces a one-cycle pulse.

A separate combinational lookup port takes a flash offset and reports whether that offset lies in the unprivileged area. When the global security enable is low, the lookup port reports every offset as unprivileged, whatever the stored length.

Top module: `fwm_watermark`

## Requirements
- R1: After reset the register reads 0x0FFF_0000, which is a page length of 0xFFF. With security enabled, every offset then looks up as unprivileged.
- R2: An accepted write stores write-data bits 27:16 as the page length. Bits 31:28 and 15:0 always read back as zero.
- R3: For a stored length N between 1 and 0x7F, with security enabled, offsets 0 to N*2048-1 look up as unprivileged (lk_unpriv=1). Offsets N*2048 and above look up as privileged (lk_unpriv=0).
- R4: A stored length of 0 with security enabled makes every offset from 0x00000 to 0x3FFFF privileged.
- R5: Any stored length of 0x080 or more acts as 0x080, so every offset from 0x00000 to 0x3FFFF is unprivileged. The stored value itself reads back unchanged.
- R6: With flash_secure_opt=1, only a write that is both secure and privileged is accepted.
- R7: With flash_secure_opt=0, a privileged write is accepted whether it is secure or non-secure. An unprivileged write is never accepted.
- R8: A read at the register address returns the stored image for all four combinations of secure and privileged attributes. reg_rdata is registered: it shows the value held before the cycle of the read strobe, one clock after that strobe, and holds until the next read.
- R9: While cfg_lock=1, every write to the register is dropped and the stored value is unchanged.
- R10: With sec_enable=0, the register is still written and read normally, and every offset looks up as unprivileged.
- R11: A write to the register address that is dropped raises wr_illegal for exactly the following cycle. Accepted writes, and cycles without a write to the register address, leave wr_illegal at 0.
- R12: A read at any other address returns zero. A write to any other address changes nothing and raises no wr_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (12) | Register byte address; the watermark sits at REG_OFFSET (0x130) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| attr_secure | input | 1 | Transaction is secure |
| attr_priv | input | 1 | Transaction is privileged |
| sec_enable | input | 1 | Global security enable; 0 bypasses the lookup check |
| flash_secure_opt | input | 1 | Flash-secure option; 1 restricts writes to secure privileged |
| cfg_lock | input | 1 | Configuration lock from another block; 1 blocks all writes |
| reg_rdata | output | DATA_W (32) | Registered read data |
| wr_illegal | output | 1 | One-cycle pulse after a dropped write |
| lk_offset | input | OFFS_W (18) | Flash offset to classify |
| lk_unpriv | output | 1 | 1 when lk_offset is in the unprivileged area |

## Verification
The bench builds the block with its default parameters: a 12-bit length field, an 18-bit offset and a 2 KB page. With these values the reset length 0xFFF lies far above the 0x80 clamp, so the clamped path is active straight out of reset. Lengths just below, at and above 0x80 can each be written and probed at the top offset 0x3FFFF. Because the page count is only 128, the bench can place probes on both sides of a chosen page edge and at both ends of the flash. A randomized stretch mixes attributes, the option bit, the lock, the enable and addresses, and checks the output against the behavioural model on every clock.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

  typedef struct packed {
    logic secure;
    logic priv;
  } fwm_attr_t;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_ACCEPT = 2'd1,
    WR_REJECT = 2'd2
  } fwm_wr_t;

endpackage

// File: rtl/fwm_access_gate.sv
module fwm_access_gate
  import fwm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned REG_OFFSET = 'h130
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  fwm_attr_t         attr,
  input  logic              fs_opt,
  input  logic              lock,
  output fwm_wr_t           decision
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  logic hit;
  logic allowed;

  always_comb begin
    hit     = (addr == HIT_ADDR);
    allowed = !lock && attr.priv && (attr.secure || !fs_opt);
    if (!(wr && hit))
      decision = WR_NONE;
    else if (allowed)
      decision = WR_ACCEPT;
    else
      decision = WR_REJECT;
  end

endmodule

// File: rtl/fwm_len_reg.sv
module fwm_len_reg
  import fwm_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned LEN_LSB   = 16,
  parameter int unsigned RESET_LEN = 'hFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  fwm_wr_t           decision,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic              rd_hit,
  output logic [LEN_W-1:0]  len_q,
  output logic [DATA_W-1:0] rdata,
  output logic              illegal
);

  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-LEN_W){1'b0}}, {LEN_W{1'b1}}} << LEN_LSB;
  localparam logic [DATA_W-1:0] RST_IMG = DATA_W'(RESET_LEN) << LEN_LSB;

  logic [DATA_W-1:0] img_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      img_q   <= RST_IMG;
      rdata   <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= (decision == WR_REJECT);
      if (rd)
        rdata <= rd_hit ? img_q : '0;
      if (decision == WR_ACCEPT)
        img_q <= wdata & FIELD_MASK;
    end
  end

  assign len_q = img_q[LEN_LSB +: LEN_W];

endmodule

// File: rtl/fwm_lookup.sv
module fwm_lookup #(
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned OFFS_W = 18,
  parameter int unsigned GRAN_W = 11
) (
  input  logic [LEN_W-1:0]  len,
  input  logic              sec_en,
  input  logic [OFFS_W-1:0] offset,
  output logic              unpriv
);

  localparam int unsigned PAGE_W     = OFFS_W - GRAN_W;
  localparam int unsigned FULL_PAGES = 1 << PAGE_W;

  logic [PAGE_W:0]   eff_len;
  logic [OFFS_W:0]   limit;

  generate
    if (LEN_W > PAGE_W) begin : g_sat
      always_comb begin
        if (len >= LEN_W'(FULL_PAGES))
          eff_len = (PAGE_W+1)'(FULL_PAGES);
        else
          eff_len = len[PAGE_W:0];
      end
    end else begin : g_nosat
      always_comb eff_len = (PAGE_W+1)'(len);
    end
  endgenerate

  always_comb begin
    limit  = {eff_len, {GRAN_W{1'b0}}};
    unpriv = !sec_en || ({1'b0, offset} < limit);
  end

endmodule

// File: rtl/fwm_watermark.sv
module fwm_watermark
  import fwm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned REG_OFFSET = 'h130,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned LEN_LSB    = 16,
  parameter int unsigned RESET_LEN  = 'hFFF,
  parameter int unsigned OFFS_W     = 18,
  parameter int unsigned GRAN_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              attr_secure,
  input  logic              attr_priv,
  input  logic              sec_enable,
  input  logic              flash_secure_opt,
  input  logic              cfg_lock,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wr_illegal,
  input  logic [OFFS_W-1:0] lk_offset,
  output logic              lk_unpriv
);

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

  fwm_attr_t        attr;
  fwm_wr_t          decision;
  logic [LEN_W-1:0] len_q;
  logic             rd_hit;

  assign attr   = '{secure: attr_secure, priv: attr_priv};
  assign rd_hit = (reg_addr == HIT_ADDR);

  fwm_access_gate #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) u_gate (
    .wr      (reg_wr),
    .addr    (reg_addr),
    .attr    (attr),
    .fs_opt  (flash_secure_opt),
    .lock    (cfg_lock),
    .decision(decision)
  );

  fwm_len_reg #(
    .DATA_W   (DATA_W),
    .LEN_W    (LEN_W),
    .LEN_LSB  (LEN_LSB),
    .RESET_LEN(RESET_LEN)
  ) u_reg (
    .clk     (clk),
    .rst     (rst),
    .decision(decision),
    .wdata   (reg_wdata),
    .rd      (reg_rd),
    .rd_hit  (rd_hit),
    .len_q   (len_q),
    .rdata   (reg_rdata),
    .illegal (wr_illegal)
  );

  fwm_lookup #(
    .LEN_W (LEN_W),
    .OFFS_W(OFFS_W),
    .GRAN_W(GRAN_W)
  ) u_lookup (
    .len   (len_q),
    .sec_en(sec_enable),
    .offset(lk_offset),
    .unpriv(lk_unpriv)
  );

endmodule

// File: rtl/fwm_watermark_chk.sv
module fwm_watermark_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned REG_OFFSET = 'h130,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned LEN_LSB    = 16,
  parameter int unsigned OFFS_W     = 18,
  parameter int unsigned GRAN_W     = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              attr_secure,
  input logic              attr_priv,
  input logic              sec_enable,
  input logic              flash_secure_opt,
  input logic              cfg_lock,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              wr_illegal,
  input logic              lk_unpriv,
  input logic [LEN_W-1:0]  len_q
);

  localparam logic [ADDR_W-1:0] HIT_ADDR   = ADDR_W'(REG_OFFSET);
  localparam int unsigned       FULL_PAGES = 1 << (OFFS_W - GRAN_W);
  localparam logic [DATA_W-1:0] RSV_MASK   =
    ~({{(DATA_W-LEN_W){1'b0}}, {LEN_W{1'b1}}} << LEN_LSB);

  // R11
  drop_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == HIT_ADDR &&
     (cfg_lock || !attr_priv || (flash_secure_opt && !attr_secure)))
    |=> wr_illegal);

  // R11
  no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == HIT_ADDR) |=> !wr_illegal);

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_lock |=> $stable(len_q));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & RSV_MASK) == '0);

  // R10
  bypass_unpriv_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_enable |-> lk_unpriv);

  // R4
  empty_area_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_enable && len_q == '0) |-> !lk_unpriv);

  // R5
  full_area_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_enable && len_q >= LEN_W'(FULL_PAGES)) |-> lk_unpriv);

endmodule

bind fwm_watermark fwm_watermark_chk #(
  .ADDR_W    (ADDR_W),
  .REG_OFFSET(REG_OFFSET),
  .DATA_W    (DATA_W),
  .LEN_W     (LEN_W),
  .LEN_LSB   (LEN_LSB),
  .OFFS_W    (OFFS_W),
  .GRAN_W    (GRAN_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .reg_addr        (reg_addr),
  .reg_wr          (reg_wr),
  .attr_secure     (attr_secure),
  .attr_priv       (attr_priv),
  .sec_enable      (sec_enable),
  .flash_secure_opt(flash_secure_opt),
  .cfg_lock        (cfg_lock),
  .reg_rdata       (reg_rdata),
  .wr_illegal      (wr_illegal),
  .lk_unpriv       (lk_unpriv),
  .len_q           (len_q)
);

// File: tb/fwm_watermark_tb.sv
module fwm_watermark_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] REG_A = 12'h130;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata;
  logic        attr_secure, attr_priv;
  logic        sec_enable, flash_secure_opt, cfg_lock;
  logic [31:0] reg_rdata;
  logic        wr_illegal;
  logic [17:0] lk_offset;
  logic        lk_unpriv;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  int          m_len;
  logic [31:0] m_rdata;
  bit          m_ill;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwm_watermark u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .attr_secure(attr_secure), .attr_priv(attr_priv),
    .sec_enable(sec_enable), .flash_secure_opt(flash_secure_opt), .cfg_lock(cfg_lock),
    .reg_rdata(reg_rdata), .wr_illegal(wr_illegal), .lk_offset(lk_offset),
    .lk_unpriv(lk_unpriv)
  );

  task automatic model_step();
    bit hit, ok;
    hit = (reg_addr == REG_A);
    ok  = !cfg_lock && attr_priv && (attr_secure || !flash_secure_opt);
    if (rst) begin
      m_len = 'hFFF; m_rdata = 0; m_ill = 0;
    end else begin
      m_ill = reg_wr && hit && !ok;
      if (reg_rd) m_rdata = hit ? (32'(m_len) << 16) : 32'h0;
      if (reg_wr && hit && ok) m_len = int'(reg_wdata[27:16]);
    end
  endtask

  function automatic bit exp_unpriv();
    int eff;
    eff = (m_len >= 'h80) ? 'h80 : m_len;
    return !sec_enable || (int'(lk_offset) < eff * 2048);
  endfunction

  task automatic cmp(string tag);
    bit eu;
    eu = exp_unpriv();
    checks += 3;
    if (reg_rdata !== m_rdata) begin
      errors++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, reg_rdata, m_rdata);
    end
    if (wr_illegal !== m_ill) begin
      errors++;
      $display("FAIL %s wr_illegal actual=%b expected=%b", tag, wr_illegal, m_ill);
    end
    if (lk_unpriv !== eu) begin
      errors++;
      $display("FAIL %s lk_unpriv offset=%h actual=%b expected=%b", tag, lk_offset, lk_unpriv, eu);
    end
  endtask

  // one clock: inputs already set, model follows the edge, compare at negedge
  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp(tag);
    reg_wr = 0; reg_rd = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, bit s, bit p, string tag);
    reg_addr = a; reg_wdata = d; attr_secure = s; attr_priv = p; reg_wr = 1;
    cyc(tag);
  endtask

  task automatic rd(logic [11:0] a, bit s, bit p, string tag);
    reg_addr = a; attr_secure = s; attr_priv = p; reg_rd = 1;
    cyc(tag);
  endtask

  task automatic probe(logic [17:0] off, string tag);
    lk_offset = off;
    cyc(tag);
  endtask

  task automatic set_len(int n);
    flash_secure_opt = 0; cfg_lock = 0;
    wr(REG_A, 32'(n) << 16, 1, 1, "R2");
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0;
    attr_secure = 0; attr_priv = 0; sec_enable = 1; flash_secure_opt = 0;
    cfg_lock = 0; lk_offset = 18'h3FFFF;
    m_len = 'hFFF; m_rdata = 0; m_ill = 0;
    cyc("R1"); cyc("R1");
    rst = 0;
    // R1: reset image and full unprivileged lookup
    rd(REG_A, 0, 0, "R1");
    cyc("R1");
    probe(18'h3FFFF, "R1");
    // R2: field capture, reserved bits read zero
    wr(REG_A, 32'hFFFF_FFFF, 1, 1, "R2");
    rd(REG_A, 1, 1, "R2");
    wr(REG_A, 32'h0123_4567, 1, 1, "R2");
    rd(REG_A, 1, 1, "R2");
    cyc("R2");
    // R3: boundary of a 5-page area
    set_len(5);
    probe(18'd0, "R3");
    probe(18'd10239, "R3");
    probe(18'd10240, "R3");
    probe(18'h3FFFF, "R3");
    set_len('h7F);
    probe(18'h3F7FF, "R3");
    probe(18'h3F800, "R3");
    // R4: empty area
    set_len(0);
    probe(18'd0, "R4");
    probe(18'h3FFFF, "R4");
    // R5: clamp at 0x80
    set_len('h80);
    probe(18'h3FFFF, "R5");
    set_len('h81);
    probe(18'h3FFFF, "R5");
    set_len('h7FF);
    probe(18'h3FFFF, "R5");
    rd(REG_A, 0, 1, "R5");
    cyc("R5");
    // R6: option set restricts to secure privileged
    flash_secure_opt = 1;
    wr(REG_A, 32'h0003_0000, 0, 1, "R6");
    cyc("R6");
    wr(REG_A, 32'h0003_0000, 1, 0, "R6");
    wr(REG_A, 32'h0004_0000, 1, 1, "R6");
    rd(REG_A, 0, 0, "R6");
    cyc("R6");
    // R7: option clear admits any privileged write
    flash_secure_opt = 0;
    wr(REG_A, 32'h0009_0000, 0, 1, "R7");
    wr(REG_A, 32'h000A_0000, 1, 0, "R7");
    wr(REG_A, 32'h000B_0000, 0, 0, "R7");
    rd(REG_A, 0, 0, "R7");
    cyc("R7");
    // R8: reads under every attribute pair
    rd(REG_A, 0, 0, "R8");
    rd(REG_A, 0, 1, "R8");
    rd(REG_A, 1, 0, "R8");
    rd(REG_A, 1, 1, "R8");
    cyc("R8");
    // R9: lock blocks even secure privileged
    cfg_lock = 1;
    wr(REG_A, 32'h0022_0000, 1, 1, "R9");
    rd(REG_A, 1, 1, "R9");
    cyc("R9");
    cfg_lock = 0;
    // R10: bypass with security disabled
    set_len(0);
    sec_enable = 0;
    probe(18'd0, "R10");
    probe(18'h3FFFF, "R10");
    wr(REG_A, 32'h0033_0000, 0, 1, "R10");
    rd(REG_A, 0, 0, "R10");
    cyc("R10");
    sec_enable = 1;
    // R11: pulse lasts one cycle
    wr(REG_A, 32'h0, 0, 0, "R11");
    cyc("R11");
    // R12: other addresses
    rd(12'h134, 1, 1, "R12");
    wr(12'h134, 32'h0077_0000, 1, 1, "R12");
    wr(12'h12C, 32'h0077_0000, 0, 0, "R12");
    rd(REG_A, 1, 1, "R12");
    cyc("R12");
    // mixed stimulus compared every clock
    for (int i = 0; i < 1500; i++) begin
      reg_addr         = ($urandom_range(0, 3) == 0) ? 12'h138 : REG_A;
      reg_wr           = $urandom_range(0, 1);
      reg_rd           = $urandom_range(0, 1);
      reg_wdata        = $urandom;
      reg_wdata[27:16] = ($urandom_range(0, 1) == 1) ? 12'($urandom_range(0, 'h90)) : reg_wdata[27:16];
      attr_secure      = $urandom_range(0, 1);
      attr_priv        = $urandom_range(0, 1);
      flash_secure_opt = $urandom_range(0, 1);
      cfg_lock         = ($urandom_range(0, 4) == 0);
      sec_enable       = ($urandom_range(0, 5) != 0);
      lk_offset        = 18'($urandom);
      cyc("R11");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule